// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block converts a segment/offset pair into a linear address in one of two modes. In real mode it multiplies the 16-bit segment value by sixteen, adds a 16-bit offset, and keeps 20 bits of the sum, so the result wraps at 1 MB. In protected mode it adds an offset to the 32-bit base of a descriptor that the caller has already cached. Before it adds, it checks the last byte of the access against the descriptor's 20-bit limit, which the granularity bit scales. The descriptor's default-size bit picks 16-bit or 32-bit offsets and also sets the reported default operand and stack width.

A request is taken when `req_valid` is high. Exactly one cycle later the result appears on the output side with `rsp_valid` high. It carries the linear address, a fault flag and the width indication. A faulting access returns an address of zero. With no paging downstream, `lin_addr` serves directly as the physical address.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`prot_mode`=0), `lin_addr` equals `seg_val`*16 + `offset[15:0]` reduced to 20 bits, and bits 31..20 are zero. For example, 1100h:0450h gives 11450h.
- R2: In real mode, any carry out of bit 19 is dropped. For example, FFFFh:0010h gives 00000h.
- R3: Real mode never faults, and it ignores `offset[31:16]` and all descriptor inputs. Two different pairs that map to the same address both return that address with `fault`=0.
- R4: In protected mode, when no fault occurs, `lin_addr` equals `desc_base` + effective offset, taken modulo 2^32.
- R5: With `desc_gran`=0, the effective limit is `desc_limit` in bytes. An access faults exactly when effective offset + size - 1 is greater than that limit.
- R6: With `desc_gran`=1, the effective limit is `desc_limit` followed by twelve 1 bits, i.e. `desc_limit`*4096 + 4095.
- R7: With `desc_db`=0, the offset is cut to its low 16 bits before both the limit check and the addition. With `desc_db`=1, all 32 bits are used.
- R8: `acc_size` gives the access width as 2^`acc_size` bytes (0:1, 1:2, 2:4, 3:8). The last-byte sum is formed without wrapping.
- R9: Whenever `fault`=1, `lin_addr` is zero.
- R10: `rsp_valid` is `req_valid` delayed by one clock. The result registers change only on a request, so they hold their values while no request arrives.
- R11: `wide_out` is 1 exactly for a protected-mode request with `desc_db`=1, and it is registered with the result.
- R12: After reset, `rsp_valid`, `fault`, `wide_out` and `lin_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when it is high |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| seg_val | input | 16 | Real-mode segment value |
| offset | input | 32 | Logical offset |
| acc_size | input | 2 | Access width code, 2^n bytes |
| desc_base | input | 32 | Cached descriptor base |
| desc_limit | input | 20 | Cached descriptor limit |
| desc_gran | input | 1 | Limit unit: 0 = bytes, 1 = 4 KB pages |
| desc_db | input | 1 | Default size: 0 = 16-bit, 1 = 32-bit |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| lin_addr | output | 32 | Linear address (zero on fault) |
| fault | output | 1 | Limit violation |
| wide_out | output | 1 | 32-bit default operand/stack width |

## Verification
The bench targets accesses whose last byte sits exactly on the limit and one byte past it, under both granularities and with multi-byte sizes. A design that compares the start offset, or that scales the page limit without filling the low twelve bits, gives the wrong fault result in those cases. It also sends real-mode pairs that wrap past 1 MB or alias the same address while the descriptor inputs hold garbage, which exposes a design that keeps bit 20 or applies the limit in real mode. A 16-bit request with nonzero upper offset bits and a protected base-plus-offset that wraps at 4 GB catch missing truncation and a wrong adder width. Back-to-back and idle cycles catch a latency or hold error.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEG_W      = 16;
    localparam int ADDR_W     = 32;
    localparam int LIM_W      = 20;
    localparam int NARROW_W   = 16;
    localparam int REAL_SHIFT = 4;
    localparam int GRAN_SHIFT = 12;
    localparam int SIZE_W     = 2;

    localparam int REAL_AW = SEG_W + REAL_SHIFT;
    localparam int LAST_W  = ADDR_W + 1;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } xlate_mode_e;

    typedef struct packed {
        xlate_mode_e         mode;
        logic [SEG_W-1:0]    seg;
        logic [ADDR_W-1:0]   off;
        logic [SIZE_W-1:0]   size;
        logic [ADDR_W-1:0]   base;
        logic [LIM_W-1:0]    limit;
        logic                gran;
        logic                db;
    } xlate_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0]   lin;
        logic                fault;
        logic                wide;
    } xlate_rsp_t;

    // Bytes covered by an access beyond its first byte.
    function automatic logic [LAST_W-1:0] size_extra(input logic [SIZE_W-1:0] code);
        logic [LAST_W-1:0] one;
        one = LAST_W'(1);
        return (one << code) - one;
    endfunction

    // Limit after scaling by the granularity bit.
    function automatic logic [LAST_W-1:0] scaled_limit(input logic [LIM_W-1:0] lim,
                                                       input logic gran);
        if (gran)
            return LAST_W'({lim, {GRAN_SHIFT{1'b1}}});
        return LAST_W'(lim);
    endfunction

endpackage

// File: rtl/seg_real_calc.sv
module seg_real_calc
    import seg_xlate_pkg::*;
(
    input  logic [SEG_W-1:0]    seg,
    input  logic [NARROW_W-1:0] off_lo,
    output logic [ADDR_W-1:0]   lin
);
    logic [REAL_AW-1:0] seg_scaled;
    logic [REAL_AW-1:0] off_ext;
    logic [REAL_AW-1:0] sum;

    always_comb begin
        seg_scaled = {seg, {REAL_SHIFT{1'b0}}};
        off_ext    = REAL_AW'(off_lo);
        sum        = seg_scaled + off_ext;   // carry beyond REAL_AW is dropped
        lin        = ADDR_W'(sum);
    end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_xlate_pkg::*;
(
    input  logic [ADDR_W-1:0] off_eff,
    input  logic [SIZE_W-1:0] size,
    input  logic [LIM_W-1:0]  limit,
    input  logic              gran,
    output logic              over
);
    logic [LAST_W-1:0] last_byte;
    logic [LAST_W-1:0] bound;

    always_comb begin
        last_byte = {1'b0, off_eff} + size_extra(size);
        bound     = scaled_limit(limit, gran);
        over      = (last_byte > bound);
    end
endmodule

// File: rtl/seg_prot_calc.sv
module seg_prot_calc
    import seg_xlate_pkg::*;
(
    input  xlate_req_t        req,
    output logic [ADDR_W-1:0] lin,
    output logic              over
);
    logic [ADDR_W-1:0] off_eff;
    logic [ADDR_W-1:0] off_narrow;

    generate
        if (NARROW_W < ADDR_W) begin : g_trunc
            assign off_narrow = ADDR_W'(req.off[NARROW_W-1:0]);
        end else begin : g_full
            assign off_narrow = req.off;
        end
    endgenerate

    assign off_eff = req.db ? req.off : off_narrow;

    seg_limit_chk u_lim (
        .off_eff (off_eff),
        .size    (req.size),
        .limit   (req.limit),
        .gran    (req.gran),
        .over    (over)
    );

    assign lin = req.base + off_eff;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              prot_mode,
    input  logic [15:0]       seg_val,
    input  logic [31:0]       offset,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       desc_base,
    input  logic [19:0]       desc_limit,
    input  logic              desc_gran,
    input  logic              desc_db,
    output logic              rsp_valid,
    output logic [31:0]       lin_addr,
    output logic              fault,
    output logic              wide_out
);
    xlate_req_t        req;
    xlate_rsp_t        nxt;
    xlate_rsp_t        cur;
    logic [ADDR_W-1:0] real_lin;
    logic [ADDR_W-1:0] prot_lin;
    logic              prot_over;

    always_comb begin
        req.mode  = prot_mode ? MODE_PROT : MODE_REAL;
        req.seg   = seg_val;
        req.off   = offset;
        req.size  = acc_size;
        req.base  = desc_base;
        req.limit = desc_limit;
        req.gran  = desc_gran;
        req.db    = desc_db;
    end

    seg_real_calc u_real (
        .seg    (req.seg),
        .off_lo (req.off[NARROW_W-1:0]),
        .lin    (real_lin)
    );

    seg_prot_calc u_prot (
        .req  (req),
        .lin  (prot_lin),
        .over (prot_over)
    );

    always_comb begin
        nxt = '0;
        unique case (req.mode)
            MODE_REAL: begin
                nxt.lin   = real_lin;
                nxt.fault = 1'b0;
                nxt.wide  = 1'b0;
            end
            MODE_PROT: begin
                nxt.fault = prot_over;
                nxt.lin   = prot_over ? '0 : prot_lin;
                nxt.wide  = req.db;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid)
                cur <= nxt;
        end
    end

    assign lin_addr = cur.lin;
    assign fault    = cur.fault;
    assign wide_out = cur.wide;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        prot_mode,
    input logic        desc_db,
    input logic        rsp_valid,
    input logic [31:0] lin_addr,
    input logic        fault,
    input logic        wide_out
);
    // R10
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(lin_addr) && $stable(fault)));

    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (lin_addr == 32'h0));

    // R3
    real_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !prot_mode) |=> !fault);

    // R2
    real_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !prot_mode) |=> (lin_addr[31:20] == 12'h0));

    // R11
    wide_flag_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (wide_out == $past(prot_mode && desc_db)));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .prot_mode (prot_mode),
    .desc_db   (desc_db),
    .rsp_valid (rsp_valid),
    .lin_addr  (lin_addr),
    .fault     (fault),
    .wide_out  (wide_out)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        prot_mode = 1'b0;
    logic [15:0] seg_val = '0;
    logic [31:0] offset = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic        desc_db = 1'b0;
    logic        rsp_valid;
    logic [31:0] lin_addr;
    logic        fault;
    logic        wide_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] lin;
        logic        flt;
        logic        wide;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [31:0] last_lin;
    logic        last_flt;

    always #5 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .prot_mode(prot_mode),
        .seg_val(seg_val), .offset(offset), .acc_size(acc_size),
        .desc_base(desc_base), .desc_limit(desc_limit), .desc_gran(desc_gran),
        .desc_db(desc_db), .rsp_valid(rsp_valid), .lin_addr(lin_addr),
        .fault(fault), .wide_out(wide_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one request at a falling edge and queues its expected result.
    task automatic send(input string tag, input bit pm, input logic [15:0] sg,
                        input logic [31:0] off, input logic [1:0] sz,
                        input logic [31:0] base, input logic [19:0] lim,
                        input bit gr, input bit db);
        exp_t e;
        longint unsigned o, last, bound;
        e.tag = tag;
        if (!pm) begin
            e.lin  = 32'((longint'(sg) * 16 + longint'(off[15:0])) % 64'h100000);
            e.flt  = 1'b0;
            e.wide = 1'b0;
        end else begin
            o     = db ? longint'(off) : longint'(off[15:0]);
            last  = o + (64'd1 << sz) - 1;
            bound = gr ? longint'(lim) * 4096 + 4095 : longint'(lim);
            e.flt  = (last > bound);
            e.lin  = e.flt ? 32'h0 : 32'((longint'(base) + o) % 64'h100000000);
            e.wide = db;
        end
        sb.push_back(e);
        req_valid  = 1'b1;
        prot_mode  = pm;
        seg_val    = sg;
        offset     = off;
        acc_size   = sz;
        desc_base  = base;
        desc_limit = lim;
        desc_gran  = gr;
        desc_db    = db;
        @(negedge clk);
    endtask

    // Monitor: compares each response with the oldest queued item.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected response", 64'(lin_addr), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(lin_addr == e.lin, {e.tag, " lin_addr"}, 64'(lin_addr), 64'(e.lin));
                check(fault == e.flt, {e.tag, " fault"}, 64'(fault), 64'(e.flt));
                check(wide_out == e.wide, {e.tag, " R11 wide_out"}, 64'(wide_out), 64'(e.wide));
                last_lin = e.lin;
                last_flt = e.flt;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(rsp_valid == 1'b0, "R12 rsp_valid", 64'(rsp_valid), 64'h0);
        check(lin_addr == 32'h0, "R12 lin_addr", 64'(lin_addr), 64'h0);
        check(fault == 1'b0 && wide_out == 1'b0, "R12 fault/wide", 64'({fault, wide_out}), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // Real mode
        send("R1 1100:0450", 0, 16'h1100, 32'h0000_0450, 0, 32'h0, 20'h0, 0, 0);
        send("R3 alias 1145:0000", 0, 16'h1145, 32'h0000_0000, 3, 32'hDEAD_BEEF, 20'h00000, 1, 1);
        send("R2 wrap FFFF:0010", 0, 16'hFFFF, 32'h0000_0010, 0, 32'h0, 20'h0, 0, 0);
        send("R3 upper offset ignored", 0, 16'h0000, 32'hABCD_0005, 2, 32'h1234_5678, 20'h0, 0, 1);
        send("R1 FFFF:FFFF", 0, 16'hFFFF, 32'h0000_FFFF, 0, 32'h0, 20'h0, 0, 0);
        req_valid = 1'b0;
        @(negedge clk);

        // Protected mode
        send("R4 base+off", 1, 16'h0, 32'h0000_1234, 2, 32'h0040_0000, 20'hFFFFF, 1, 1);
        send("R4 wrap 4GB", 1, 16'h0, 32'h0000_2000, 0, 32'hFFFF_F000, 20'hFFFFF, 1, 1);
        send("R5 last byte at limit", 1, 16'h0, 32'h0000_0FFF, 0, 32'h0010_0000, 20'h00FFF, 0, 1);
        send("R5 one past limit", 1, 16'h0, 32'h0000_0FFF, 1, 32'h0010_0000, 20'h00FFF, 0, 1);
        send("R8 4-byte ends at limit", 1, 16'h0, 32'h0000_0FFC, 2, 32'h0010_0000, 20'h00FFF, 0, 1);
        send("R8 4-byte crosses limit", 1, 16'h0, 32'h0000_0FFD, 2, 32'h0010_0000, 20'h00FFF, 0, 1);
        send("R6 page limit top", 1, 16'h0, 32'h0000_1FFF, 0, 32'h0200_0000, 20'h00001, 1, 1);
        send("R6 page limit past", 1, 16'h0, 32'h0000_2000, 0, 32'h0200_0000, 20'h00001, 1, 1);
        send("R7 narrow truncation", 1, 16'h0, 32'h1234_5678, 0, 32'h0001_0000, 20'h0FFFF, 0, 0);
        send("R7 narrow vs tight limit", 1, 16'h0, 32'h0001_0010, 0, 32'h0001_0000, 20'h00020, 0, 0);
        send("R7 wide no truncation", 1, 16'h0, 32'h0001_0010, 0, 32'h0001_0000, 20'h00020, 0, 1);
        send("R8 8-byte ok", 1, 16'h0, 32'h0000_FFF8, 3, 32'h0, 20'h0FFFF, 0, 0);
        send("R8 8-byte fault", 1, 16'h0, 32'h0000_FFF9, 3, 32'h0, 20'h0FFFF, 0, 0);
        send("R8 narrow no wrap", 1, 16'h0, 32'h0000_FFFF, 1, 32'h0, 20'hFFFFF, 0, 0);
        send("R9 fault then real", 1, 16'h0, 32'h0000_0100, 0, 32'h0500_0000, 20'h000FF, 0, 1);
        send("R4 last valid", 1, 16'h0, 32'h0000_0010, 0, 32'h0500_0000, 20'h000FF, 0, 1);
        req_valid = 1'b0;
        @(negedge clk);
        // Change inputs while idle; results must hold (R10).
        prot_mode = 1'b1;
        offset    = 32'hFFFF_FFFF;
        desc_base = 32'h7777_0000;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle rsp_valid", 64'(rsp_valid), 64'h0);
        check(lin_addr == last_lin && fault == last_flt, "R10 hold while idle",
              64'(lin_addr), 64'(last_lin));
        check(sb.size() == 0, "R10 all responses seen", 64'(sb.size()), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule